// File: doc/BRIEF.md
# Refresh-Counted Slow Clock Generator

This block produces a slow square wave whose edges are paced by completed scan-chain refreshes rather than by the system clock. Each time the scan controller finishes a refresh it raises a one-cycle strobe. The block counts these strobes and inverts its slow clock after every N+1 of them. The slow clock's frequency is therefore the refresh rate divided by 2·(N+1).

The ratio N is an 8-bit value taken from the input bus when the enable input goes high. The enable input is asynchronous to the system clock, so it first passes through a two-flop synchroniser before its rising edge is detected. While the block is enabled, the slow clock replaces bit 0 of the input byte sent to the selected design, and it is also driven on a dedicated output pin. While the block is disabled, bit 0 carries the user's own input bit and the slow clock pin stays low.

Top module: `scan_slow_clock`

## Requirements
- R1: A rising edge on `div_en`, seen after a two-flop synchroniser, captures the full 8-bit value of `in_bus` as the ratio N. The synchronised enable goes high on the second clock edge after `div_en` rises, and the capture happens on the third.
- R2: While the synchronised enable is low, `slow_clk_o` is 0 and refresh strobes are ignored.
- R3: With N = 0, `slow_clk_o` inverts on every refresh strobe.
- R4: With any N from 0 to 255, `slow_clk_o` inverts once every N+1 strobes. After k strobes counted from the capture, `slow_clk_o` equals (k / (N+1)) mod 2, using integer division.
- R5: Clock cycles without a refresh strobe never advance the count or change `slow_clk_o`.
- R6: A capture clears the strobe count to zero and restarts `slow_clk_o` from 0, whatever phase the earlier run had reached.
- R7: While enabled, `dut_in0_o` equals `slow_clk_o`. While disabled, `dut_in0_o` equals `in_bus[0]`.
- R8: Changes on `in_bus` while `div_en` stays high do not change the ratio in use.
- R9: After reset, `slow_clk_o` is 0, the count is 0 and the ratio is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refresh_done | input | 1 | One-cycle strobe marking a completed scan refresh |
| in_bus | input | 8 | User input byte; also the source of the ratio |
| div_en | input | 1 | Divider enable, asynchronous to clk |
| slow_clk_o | output | 1 | Slow clock |
| dut_in0_o | output | 1 | Bit 0 sent to the selected design |

## Verification
The bench sweeps ratios 0 through 9 and also the largest ratio, 255. It inserts idle cycles between strobes, so a divider that counted clock cycles instead of strobes, or that was off by one in its terminal count, shows up as a wrong phase after a few strobes. Each run is stopped partway through and then restarted, so a design that kept a stale count or a stale output level fails the first toggle of the next run. The bench also changes `in_bus` during a run, strobes the block while it is disabled, and checks the input bit 0 passthrough. These catch a design that re-samples the ratio, that keeps counting while off, or that misroutes the multiplexer.

// File: rtl/scan_slow_clock_pkg.sv
package scan_slow_clock_pkg;
    localparam int unsigned RATIO_W_DEF     = 8;
    localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/ssc_en_sync.sv
module ssc_en_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_async,
    output logic en_level,
    output logic en_rise
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[DEPTH-2:0], en_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign en_level = sync_q[STAGES-1];
    assign en_rise  = sync_q[STAGES-1] & ~sync_q[STAGES];

    // R1: an edge is reported for a single cycle only
    a_r1_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !en_rise);
endmodule

// File: rtl/ssc_divider.sv
module ssc_divider #(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_level,
    input  logic               en_rise,
    input  logic               refresh_done,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               slow_q_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] cnt;
        logic               slow;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_rise) begin
            st_d.ratio = ratio_in;
            st_d.cnt   = '0;
            st_d.slow  = 1'b0;
        end else if (!en_level) begin
            st_d.cnt   = '0;
            st_d.slow  = 1'b0;
        end else if (refresh_done) begin
            if (st_q.cnt == st_q.ratio) begin
                st_d.cnt  = '0;
                st_d.slow = ~st_q.slow;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slow_q_o = st_q.slow;

    // R1, R6: a capture loads the ratio and restarts the phase
    a_r6_capture_restart: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (st_q.ratio == $past(ratio_in)) && (st_q.cnt == '0) && !st_q.slow);
    // R2: disabled means the slow clock is low on the next cycle
    a_r2_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_level |=> !st_q.slow);
    // R5: no strobe, no movement
    a_r5_hold_without_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (en_level && !en_rise && !refresh_done) |=> $stable(st_q.slow) && $stable(st_q.cnt));
    // R4: the count never passes the ratio
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.ratio);
    // R8: the ratio changes only on a capture
    a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rise |=> $stable(st_q.ratio));
endmodule

// File: rtl/scan_slow_clock.sv
module scan_slow_clock
    import scan_slow_clock_pkg::*;
#(
    parameter int unsigned RATIO_W     = RATIO_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               refresh_done,
    input  logic [RATIO_W-1:0] in_bus,
    input  logic               div_en,
    output logic               slow_clk_o,
    output logic               dut_in0_o
);
    logic en_level, en_rise, slow_q;

    ssc_en_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_async (div_en),
        .en_level (en_level),
        .en_rise  (en_rise)
    );

    ssc_divider #(.RATIO_W(RATIO_W)) div_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_level     (en_level),
        .en_rise      (en_rise),
        .refresh_done (refresh_done),
        .ratio_in     (in_bus),
        .slow_q_o     (slow_q)
    );

    assign slow_clk_o = slow_q & en_level;
    assign dut_in0_o  = en_level ? slow_clk_o : in_bus[0];

    // R7: while enabled, the design input follows the slow clock pin
    a_r7_mux_follows: assert property (@(posedge clk) disable iff (!rst_n)
        en_level |-> (dut_in0_o == slow_clk_o));
endmodule

// File: tb/scan_slow_clock_tb.sv
module scan_slow_clock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_done = 1'b0;
    logic [7:0] in_bus = 8'h00;
    logic       div_en = 1'b0;
    logic       slow_clk_o, dut_in0_o;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    scan_slow_clock dut_i (
        .clk(clk), .rst_n(rst_n), .refresh_done(refresh_done),
        .in_bus(in_bus), .div_en(div_en),
        .slow_clk_o(slow_clk_o), .dut_in0_o(dut_in0_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe();
        refresh_done = 1'b1;
        @(negedge clk);
        refresh_done = 1'b0;
        idle(2);
    endtask

    task automatic enable_with(input logic [7:0] n);
        in_bus = n;
        div_en = 1'b1;
        idle(4);
    endtask

    task automatic disable_div();
        div_en = 1'b0;
        idle(4);
    endtask

    // One run: capture N, apply strobes, check the phase after each.
    task automatic run_ratio(input int n, input int strobes);
        logic exp;
        enable_with(8'(n));
        check("R6 start low", slow_clk_o, 1'b0);
        check("R7 enabled mux", dut_in0_o, slow_clk_o);
        for (int k = 1; k <= strobes; k++) begin
            strobe();
            if (k == 1) in_bus = ~8'(n);  // R8: bus change mid-run
            exp = ((k / (n + 1)) % 2) != 0;
            check(n == 0 ? "R3 every strobe" : "R4 phase", slow_clk_o, exp);
            check("R7 enabled mux", dut_in0_o, exp);
        end
        disable_div();
        check("R2 off low", slow_clk_o, 1'b0);
        check("R7 passthrough", dut_in0_o, in_bus[0]);
    endtask

    initial begin
        idle(2);
        check("R9 reset slow", slow_clk_o, 1'b0);
        check("R9 reset in0", dut_in0_o, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // R1, R3, R4, R8: sweep small ratios
        for (int n = 0; n < 10; n++) run_ratio(n, 4 * (n + 1) + 1);

        // R2: strobes while disabled are ignored; passthrough of both values
        in_bus = 8'h01;
        for (int i = 0; i < 3; i++) strobe();
        check("R2 ignore strobe", slow_clk_o, 1'b0);
        check("R7 passthrough one", dut_in0_o, 1'b1);
        in_bus = 8'hFE;
        idle(1);
        check("R7 passthrough zero", dut_in0_o, 1'b0);

        // R5: idle cycles alone never toggle
        enable_with(8'd0);
        idle(20);
        check("R5 no strobe", slow_clk_o, 1'b0);
        strobe();
        check("R5 one strobe", slow_clk_o, 1'b1);
        idle(20);
        check("R5 hold", slow_clk_o, 1'b1);
        disable_div();

        // R6: partial count then recapture restarts the count
        enable_with(8'd2);
        strobe(); strobe();
        disable_div();
        enable_with(8'd2);
        strobe(); strobe();
        check("R6 count cleared", slow_clk_o, 1'b0);
        strobe();
        check("R6 third strobe", slow_clk_o, 1'b1);
        disable_div();

        // R4: largest ratio
        run_ratio(255, 513);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule